// File: doc/BRIEF.md
# Colour Lookup Palette Host Port

This block is the processor-facing side of a colour lookup converter. A byte-wide bus with a four-bit register select reaches two colour tables: a main table with one entry per index value and a small four-entry overlay table. Each table entry is a red, green and blue byte triple. Software loads a start index, then streams bytes through a data register. The block groups every three bytes into one colour and steps the index by itself.

Reads work the same way through a separate read index. A mode input picks whether returned components keep all eight bits or only the low six. The write index and the read index are each shared by the main table and the overlay table. A single component position counter is shared by reads and writes. An overscan colour output follows overlay entry 0 whenever that entry is written while the overscan enable input is high.

Top module: `clut_host_port`

## Requirements
- R1: The register select code is {sel_b3, sel_b2, addr_lo[1:0]}, with addr_lo in bits 1:0. The codes are: 0 write index, 1 main data, 2 pixel mask, 3 read index, 4 write index (overlay alias), 5 overlay data, 7 read index (overlay alias).
- R2: Writing code 0 or 4 loads the shared write index. Writing code 3 or 7 loads the shared read index. Either load returns the component position to red. Reading code 0 or 4 returns the write index and reading code 3 or 7 returns the read index, both zero-extended.
- R3: Data writes (code 1 or 5) are taken as red, green, blue. The entry at the write index is updated only on the blue byte, after which the write index rises by one and the position returns to red.
- R4: Data reads (code 1 or 5) return red, green, then blue of the entry at the read index. The read index rises by one after the blue byte.
- R5: With mode8 low, every returned palette component is its stored byte ANDed with 0x3F. With mode8 high, the full byte is returned. Writes always store full bytes.
- R6: Code 5 reaches a separate four-entry overlay table selected by the low two bits of the index. Overlay traffic leaves the main table unchanged.
- R7: When ovs_en is high at the blue write of overlay entry 0, ovs_color becomes {red, green, blue} of that write. ovs_color changes at no other time.
- R8: The pixel mask register (code 2) is an 8-bit read/write register that resets to 0xFF.
- R9: After reset, both indexes, the position, rd_data and ovs_color are 0.
- R10: Codes 6 and 8 to 15 read as 0xFF, and writes to them change no state.
- R11: The indexes wrap modulo 2^IDX_W and are never masked to the overlay size.
- R12: rd_data is updated on the clock edge that takes a read strobe and holds its value at all other times.
- R13: If wr_stb and rd_stb are both high in one cycle, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_lo | input | 2 | Register select bits 1:0 |
| sel_b2 | input | 1 | Register select bit 2 |
| sel_b3 | input | 1 | Register select bit 3 |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_data | input | 8 | Write byte |
| mode8 | input | 1 | 1 returns 8-bit components, 0 returns 6-bit components |
| ovs_en | input | 1 | Lets overlay entry 0 writes update the overscan colour |
| rd_data | output | 8 | Read byte, registered |
| ovs_color | output | 24 | Overscan colour {red, green, blue} |

## Verification
Every main entry is loaded with a distinct arithmetic pattern in one continuous burst, with the index wrapping at the end. The table is then read back in both component modes. This separates a wrong component order, a wrong commit point and a missing mask. The overlay is loaded from an index whose low bits are not zero, so it wraps both in the table and in the index. This shows unmasked index stepping and isolation from the main table. Partial triples cut short by an index load show that a colour is only committed on its third byte. Overscan writes with the enable on and off, to entry 0 and to other entries, show that the colour follows only the entry-0 commit.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef enum logic [3:0] {
        SEL_WIDX  = 4'd0,
        SEL_DATA  = 4'd1,
        SEL_PMASK = 4'd2,
        SEL_RIDX  = 4'd3,
        SEL_OWIDX = 4'd4,
        SEL_ODATA = 4'd5,
        SEL_ORIDX = 4'd7
    } sel_e;

    typedef struct packed {
        logic widx_ld;
        logic ridx_ld;
        logic data_wr;
        logic data_rd;
        logic ovl;
        logic pmask_wr;
    } act_t;

    localparam logic [1:0] POS_RED  = 2'd0;
    localparam logic [1:0] POS_BLUE = 2'd2;

    function automatic logic [7:0] pick_comp(rgb_t e, logic [1:0] pos, logic wide);
        logic [7:0] c;
        case (pos)
            2'd0:    c = e.r;
            2'd1:    c = e.g;
            default: c = e.b;
        endcase
        return wide ? c : {2'b00, c[5:0]};
    endfunction

endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
(
    input  logic [3:0] code,
    input  logic       wr_stb,
    input  logic       rd_stb,
    output act_t       act
);
    logic rd_go;
    assign rd_go = rd_stb & ~wr_stb;

    always_comb begin
        act = '0;
        case (code)
            SEL_WIDX, SEL_OWIDX: act.widx_ld = wr_stb;
            SEL_RIDX, SEL_ORIDX: act.ridx_ld = wr_stb;
            SEL_PMASK:           act.pmask_wr = wr_stb;
            SEL_DATA: begin
                act.data_wr = wr_stb;
                act.data_rd = rd_go;
            end
            SEL_ODATA: begin
                act.data_wr = wr_stb;
                act.data_rd = rd_go;
                act.ovl     = 1'b1;
            end
            default: act = '0;
        endcase
    end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  act_t             act,
    input  logic [7:0]       wr_data,
    output logic [IDX_W-1:0] widx_q,
    output logic [IDX_W-1:0] ridx_q,
    output logic [1:0]       pos_q,
    output rgb_t             wr_rgb,
    output logic             commit
);
    logic [7:0] red_h, grn_h;
    logic       last;

    assign last   = (pos_q == POS_BLUE);
    assign commit = act.data_wr & last;
    assign wr_rgb = '{r: red_h, g: grn_h, b: wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            widx_q <= '0;
            ridx_q <= '0;
            pos_q  <= POS_RED;
            red_h  <= '0;
            grn_h  <= '0;
        end else if (act.widx_ld) begin
            widx_q <= wr_data[IDX_W-1:0];
            pos_q  <= POS_RED;
        end else if (act.ridx_ld) begin
            ridx_q <= wr_data[IDX_W-1:0];
            pos_q  <= POS_RED;
        end else if (act.data_wr) begin
            if (pos_q == 2'd0) red_h <= wr_data;
            if (pos_q == 2'd1) grn_h <= wr_data;
            if (last) begin
                widx_q <= widx_q + IDX_W'(1);
                pos_q  <= POS_RED;
            end else begin
                pos_q  <= pos_q + 2'd1;
            end
        end else if (act.data_rd) begin
            if (last) begin
                ridx_q <= ridx_q + IDX_W'(1);
                pos_q  <= POS_RED;
            end else begin
                pos_q  <= pos_q + 2'd1;
            end
        end
    end
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int OVL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             is_ovl,
    input  logic             ovs_en,
    input  logic [IDX_W-1:0] widx,
    input  logic [IDX_W-1:0] ridx,
    input  rgb_t             wr_rgb,
    output rgb_t             main_rd,
    output rgb_t             ovl_rd,
    output rgb_t             ovs_q
);
    localparam int MAIN_DEPTH = 1 << IDX_W;
    localparam int OVL_DEPTH  = 1 << OVL_W;

    rgb_t main_q [MAIN_DEPTH];
    rgb_t ovl_q  [OVL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < MAIN_DEPTH; e++) main_q[e] <= '0;
        end else if (commit && !is_ovl) begin
            main_q[widx] <= wr_rgb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < OVL_DEPTH; e++) ovl_q[e] <= '0;
            ovs_q <= '0;
        end else if (commit && is_ovl) begin
            ovl_q[widx[OVL_W-1:0]] <= wr_rgb;
            if (ovs_en && widx[OVL_W-1:0] == '0) ovs_q <= wr_rgb;
        end
    end

    assign main_rd = main_q[ridx];
    assign ovl_rd  = ovl_q[ridx[OVL_W-1:0]];
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
    import clut_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int OVL_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  addr_lo,
    input  logic        sel_b2,
    input  logic        sel_b3,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [7:0]  wr_data,
    input  logic        mode8,
    input  logic        ovs_en,
    output logic [7:0]  rd_data,
    output logic [23:0] ovs_color
);
    logic [3:0]       code;
    act_t             act;
    logic [IDX_W-1:0] widx_q, ridx_q;
    logic [1:0]       pos_q;
    rgb_t             wr_rgb, main_rd, ovl_rd, ovs_q;
    logic             commit;
    logic [7:0]       pmask_q, rd_next, rd_q;

    assign code = {sel_b3, sel_b2, addr_lo};

    clut_decode u_dec (.code(code), .wr_stb(wr_stb), .rd_stb(rd_stb), .act(act));

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .act(act), .wr_data(wr_data),
        .widx_q(widx_q), .ridx_q(ridx_q), .pos_q(pos_q),
        .wr_rgb(wr_rgb), .commit(commit)
    );

    clut_store #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_store (
        .clk(clk), .rst(rst), .commit(commit), .is_ovl(act.ovl),
        .ovs_en(ovs_en), .widx(widx_q), .ridx(ridx_q), .wr_rgb(wr_rgb),
        .main_rd(main_rd), .ovl_rd(ovl_rd), .ovs_q(ovs_q)
    );

    always_comb begin
        case (code)
            SEL_WIDX, SEL_OWIDX: rd_next = 8'(widx_q);
            SEL_RIDX, SEL_ORIDX: rd_next = 8'(ridx_q);
            SEL_PMASK:           rd_next = pmask_q;
            SEL_DATA:            rd_next = pick_comp(main_rd, pos_q, mode8);
            SEL_ODATA:           rd_next = pick_comp(ovl_rd, pos_q, mode8);
            default:             rd_next = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask_q <= 8'hFF;
            rd_q    <= '0;
        end else begin
            if (act.pmask_wr) pmask_q <= wr_data;
            if (rd_stb && !wr_stb) rd_q <= rd_next;
        end
    end

    assign rd_data   = rd_q;
    assign ovs_color = ovs_q;
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk #(
    parameter int IDX_W = 4,
    parameter int OVL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       addr_lo,
    input logic             sel_b2,
    input logic             sel_b3,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic             ovs_en,
    input logic [1:0]       pos_q,
    input logic [IDX_W-1:0] widx_q,
    input logic [IDX_W-1:0] ridx_q,
    input logic [7:0]       rd_data,
    input logic [23:0]      ovs_color
);
    logic [3:0] c;
    assign c = {sel_b3, sel_b2, addr_lo};

    // R3: the position never leaves red, green or blue
    p_pos_range_r3: assert property (@(posedge clk) disable iff (rst)
        pos_q != 2'd3);

    // R3: a blue data write steps the write index by one
    p_widx_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && (c == 4'd1 || c == 4'd5) && pos_q == 2'd2)
        |=> widx_q == IDX_W'($past(widx_q) + 1));

    // R7: the overscan colour moves only on an enabled overlay entry-0 commit
    p_ovs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && c == 4'd5 && pos_q == 2'd2 && ovs_en && widx_q[OVL_W-1:0] == '0)
        |=> $stable(ovs_color));

    // R12: read data holds without a read strobe
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

    // R13: a write cycle never advances the read index unless it loads it
    p_ridx_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && c != 4'd3 && c != 4'd7) |=> $stable(ridx_q));
endmodule

bind clut_host_port clut_host_port_chk #(.IDX_W(IDX_W), .OVL_W(OVL_W)) chk_i (
    .clk(clk), .rst(rst), .addr_lo(addr_lo), .sel_b2(sel_b2), .sel_b3(sel_b3),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .ovs_en(ovs_en), .pos_q(pos_q),
    .widx_q(widx_q), .ridx_q(ridx_q), .rd_data(rd_data), .ovs_color(ovs_color)
);

// File: tb/clut_host_port_tb_top.sv
`timescale 1ns/1ps
module clut_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr_lo = '0;
    logic        sel_b2 = 1'b0, sel_b3 = 1'b0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        mode8 = 1'b1, ovs_en = 1'b0;
    logic [7:0]  rd_data;
    logic [23:0] ovs_color;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clut_host_port dut_i (
        .clk(clk), .rst(rst), .addr_lo(addr_lo), .sel_b2(sel_b2), .sel_b3(sel_b3),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data), .mode8(mode8),
        .ovs_en(ovs_en), .rd_data(rd_data), .ovs_color(ovs_color)
    );

    function automatic logic [7:0] mval(int i, int k);
        return 8'((i * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] oval(int s, int k);
        return 8'(8'hC0 + s * 16 + k);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] code, input logic [7:0] d);
        @(negedge clk);
        {sel_b3, sel_b2, addr_lo} = code;
        wr_data = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] code, output logic [7:0] q);
        @(negedge clk);
        {sel_b3, sel_b2, addr_lo} = code;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        q = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 ovs_color", 32'(ovs_color), 0);
        check("R9 rd_data", 32'(rd_data), 0);
        bus_rd(4'd0, q); check("R9 write index", 32'(q), 0);
        bus_rd(4'd3, q); check("R9 read index", 32'(q), 0);
        bus_rd(4'd1, q); check("R9 main entry 0 red", 32'(q), 0);
        bus_wr(4'd3, 8'd0);
        bus_rd(4'd2, q); check("R8 mask reset", 32'(q), 32'hFF);

        // R1 R2 index loads through both alias codes
        bus_wr(4'd0, 8'd5);
        bus_rd(4'd4, q); check("R2 write index alias", 32'(q), 5);
        bus_wr(4'd7, 8'd9);
        bus_rd(4'd3, q); check("R2 read index alias", 32'(q), 9);

        // R3 R11 full main sweep, index wraps back to 0
        bus_wr(4'd0, 8'd0);
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 3; k++) bus_wr(4'd1, mval(i, k));
        bus_rd(4'd0, q); check("R11 write index wrap", 32'(q), 0);

        // R4 8-bit readback
        mode8 = 1'b1;
        bus_wr(4'd3, 8'd0);
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 3; k++) begin
                bus_rd(4'd1, q);
                check($sformatf("R4 main %0d comp %0d", i, k), 32'(q), 32'(mval(i, k)));
            end
        bus_rd(4'd3, q); check("R11 read index wrap", 32'(q), 0);

        // R5 6-bit readback
        mode8 = 1'b0;
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 3; k++) begin
                bus_rd(4'd1, q);
                check($sformatf("R5 masked %0d comp %0d", i, k), 32'(q), 32'(mval(i, k) & 8'h3F));
            end
        mode8 = 1'b1;

        // R3 partial triple is dropped, index unchanged
        bus_wr(4'd0, 8'd7);
        bus_wr(4'd1, 8'hAA);
        bus_wr(4'd1, 8'hBB);
        bus_rd(4'd0, q); check("R3 no step on partial", 32'(q), 7);
        bus_wr(4'd0, 8'd7);
        bus_wr(4'd3, 8'd7);
        for (int k = 0; k < 3; k++) begin
            bus_rd(4'd1, q);
            check("R3 partial not committed", 32'(q), 32'(mval(7, k)));
        end

        // R2 read index load returns the write position to red
        bus_wr(4'd0, 8'd9);
        bus_wr(4'd1, 8'hEE);
        bus_wr(4'd3, 8'd9);
        bus_wr(4'd1, 8'h01); bus_wr(4'd1, 8'h02); bus_wr(4'd1, 8'h03);
        bus_wr(4'd3, 8'd9);
        for (int k = 0; k < 3; k++) begin
            bus_rd(4'd1, q);
            check("R2 position reset", 32'(q), k + 1);
        end

        // R6 R11 overlay from index 13, entries 1,2,3,0
        ovs_en = 1'b0;
        bus_wr(4'd4, 8'd13);
        for (int n = 0; n < 4; n++)
            for (int k = 0; k < 3; k++) bus_wr(4'd5, oval((13 + n) & 3, k));
        bus_rd(4'd4, q); check("R11 overlay index unmasked", 32'(q), 1);
        check("R7 ovs off", 32'(ovs_color), 0);
        bus_wr(4'd7, 8'd2);
        for (int n = 0; n < 4; n++)
            for (int k = 0; k < 3; k++) begin
                bus_rd(4'd5, q);
                check($sformatf("R6 overlay %0d comp %0d", (2 + n) & 3, k), 32'(q), 32'(oval((2 + n) & 3, k)));
            end
        bus_wr(4'd3, 8'd0);
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 3; k++) begin
                bus_rd(4'd1, q);
                check("R6 main untouched", 32'(q), 32'(mval(i, k)));
            end
        mode8 = 1'b0;
        bus_wr(4'd7, 8'd1);
        bus_rd(4'd5, q); check("R5 overlay masked", 32'(q), 32'(oval(1, 0) & 8'h3F));
        mode8 = 1'b1;

        // R7 overscan follows entry 0
        ovs_en = 1'b1;
        bus_wr(4'd4, 8'd4);
        bus_wr(4'd5, 8'h12); bus_wr(4'd5, 8'h34);
        check("R7 not before blue", 32'(ovs_color), 0);
        bus_wr(4'd5, 8'h56);
        check("R7 entry 0 commit", 32'(ovs_color), 32'h123456);
        bus_wr(4'd5, 8'h01); bus_wr(4'd5, 8'h02); bus_wr(4'd5, 8'h03);
        check("R7 other entry", 32'(ovs_color), 32'h123456);
        bus_wr(4'd1, 8'h0A); bus_wr(4'd1, 8'h0B); bus_wr(4'd1, 8'h0C);
        check("R7 main entry", 32'(ovs_color), 32'h123456);
        ovs_en = 1'b0;
        bus_wr(4'd4, 8'd8);
        bus_wr(4'd5, 8'h01); bus_wr(4'd5, 8'h02); bus_wr(4'd5, 8'h03);
        check("R7 disabled", 32'(ovs_color), 32'h123456);

        // R8 mask read/write
        bus_wr(4'd2, 8'h3C);
        bus_rd(4'd2, q); check("R8 mask write", 32'(q), 32'h3C);

        // R10 unused codes
        bus_wr(4'd0, 8'd6);
        bus_wr(4'd3, 8'd11);
        for (int u = 6; u < 16; u++) begin
            if (u == 7) continue;
            bus_wr(4'(u), 8'h00);
            bus_rd(4'(u), q);
            check($sformatf("R10 code %0d reads FF", u), 32'(q), 32'hFF);
        end
        bus_rd(4'd2, q); check("R10 mask kept", 32'(q), 32'h3C);
        bus_rd(4'd0, q); check("R10 write index kept", 32'(q), 6);
        bus_rd(4'd3, q); check("R10 read index kept", 32'(q), 11);
        bus_rd(4'd1, q); check("R10 position kept", 32'(q), 32'(mval(11, 0)));

        // R12 hold without read strobe
        held = rd_data;
        repeat (5) @(negedge clk);
        check("R12 hold", 32'(rd_data), 32'(held));

        // R13 write wins over read
        @(negedge clk);
        {sel_b3, sel_b2, addr_lo} = 4'd1;
        wr_data = 8'h77;
        wr_stb = 1'b1;
        rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        check("R13 read suppressed", 32'(rd_data), 32'(held));
        bus_rd(4'd3, q); check("R13 read index kept", 32'(q), 11);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule